// File: doc/BRIEF.md
# Always-on Detection Shadow Latch

This block holds a second copy of the headset-detection control fields for an always-on domain, and decides when sticky short-circuit status may be captured there. A latch-control input selects between two regimes. Frozen: the copy ignores the primary fields and sticky capture is allowed. Transparent: the copy tracks the primary fields on every clock and sticky capture is blocked. In transparent mode, a power-down-all request overrides the mode and bias settings and drives a full power-down output.

The stored detection mode also selects the source of the active-low interrupt pin. In the inactive codes the pin is held high and the sticky bits are wiped. In short-only mode the pin follows the short comparator directly, or stays high while the short-detected mask is set. In normal mode the pin goes low while any unmasked sticky bit is set. All pins are plain control and status levels or single-cycle strobes. No data stream passes through the block, so it has no handshake.

Top module: `detect_shadow_latch`

## Requirements
- R1: After reset the stored mode reads 00, the stored bias field reads 01, the tip enable reads 0, every wake-mask bit reads 1, both sticky bits read 0, `int_n` is 1 and `pwr_down` is 0.
- R2: While `latch_xfer` is 0, the stored fields keep their values whatever the primary fields do.
- R3: While `latch_xfer` is 1, each stored field equals the primary value from the previous clock edge.
- R4: While `latch_xfer` and `pdn_all` are both 1, `pwr_down` is 1 in the same cycle and the mode and bias outputs read 00. With `latch_xfer` at 0, `pdn_all` has no effect.
- R5: Sticky bit 0 (short detected) and bit 1 (short released) are set on the clock after their event strobe. This happens only when `latch_xfer` is 0 and the stored mode is 01 or 11.
- R6: Event strobes seen while `latch_xfer` is 1 set no sticky bit.
- R7: A clear strobe clears its sticky bit on the next edge (write-one-to-clear). If the event strobe and the clear strobe for a bit come in the same cycle, the bit is set.
- R8: Whenever the effective mode is 00, or the reserved code 10, both sticky bits are cleared on the next edge and cannot be set.
- R9: In mode 01, `int_n` equals `short_cmp` while mask bit 0 is 0, and is 1 while mask bit 0 is 1, with no clock delay.
- R10: In mode 11, `int_n` is 0 exactly while some sticky bit is set and its mask bit (same index) is 0.
- R11: In modes 00 and 10, `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_det_mode | input | 2 | Primary detection mode (00 off, 01 short only, 10 reserved, 11 normal) |
| pri_bias_ctl | input | 2 | Primary bias output control |
| pri_tip_en | input | 1 | Primary tip-sense enable |
| pri_wake_mask | input | WAKE_W | Primary wake masks |
| latch_xfer | input | 1 | 1 = transparent copy, 0 = frozen copy with sticky capture |
| pdn_all | input | 1 | Power-down-all request |
| short_cmp | input | 1 | Short comparator level |
| stat_mask | input | 2 | Masks: bit 0 short detected, bit 1 short released |
| stat_ev | input | 2 | Event strobes, same bit order |
| stat_clr | input | 2 | Write-one-to-clear strobes, same bit order |
| sh_det_mode | output | 2 | Effective stored detection mode |
| sh_bias_ctl | output | 2 | Effective stored bias control |
| sh_tip_en | output | 1 | Stored tip-sense enable |
| sh_wake_mask | output | WAKE_W | Stored wake masks |
| stat_sticky | output | 2 | Sticky bits, same bit order |
| pwr_down | output | 1 | Full power-down |
| int_n | output | 1 | Interrupt pin level, active low |

## Verification
The bench targets the edge where a mode change lands. A design that cleared sticky bits using the primary mode, not the stored one, would wipe them one cycle early or would keep them while the copy is frozen. It checks that an event strobe and a clear strobe arriving together leave the bit set, and that reserved code 10 behaves like 00; a naive decoder would leave interrupts live there. It also checks that a power-down request has no effect while the copy is frozen, and that the short-only interrupt path has no register in it. A design that latched the comparator would show the pin lagging by one cycle.

// File: rtl/det_shadow_pkg.sv
package det_shadow_pkg;
  typedef enum logic [1:0] {
    DM_OFF    = 2'b00,
    DM_SHORT  = 2'b01,
    DM_RSVD   = 2'b10,
    DM_NORMAL = 2'b11
  } det_mode_e;

  localparam int N_STAT   = 2;
  localparam int STAT_DET = 0;
  localparam int STAT_REL = 1;
  localparam logic [1:0] BIAS_RST = 2'b01;

  function automatic logic mode_live(input logic [1:0] m);
    return (m == DM_SHORT) || (m == DM_NORMAL);
  endfunction
endpackage

// File: rtl/det_shadow_bank.sv
module det_shadow_bank
  import det_shadow_pkg::*;
#(
  parameter int WAKE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [1:0]        pri_mode,
  input  logic [1:0]        pri_bias,
  input  logic              pri_tip,
  input  logic [WAKE_W-1:0] pri_wake,
  output logic [1:0]        st_mode,
  output logic [1:0]        st_bias,
  output logic              st_tip,
  output logic [WAKE_W-1:0] st_wake
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mode <= DM_OFF;
      st_bias <= BIAS_RST;
      st_tip  <= 1'b0;
    end else if (xfer) begin
      st_mode <= pri_mode;
      st_bias <= pri_bias;
      st_tip  <= pri_tip;
    end
  end

  for (genvar g = 0; g < WAKE_W; g++) begin : g_wake
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_wake[g] <= 1'b1;
      else if (xfer) st_wake[g] <= pri_wake[g];
    end
  end
endmodule

// File: rtl/det_sticky_cell.sv
module det_sticky_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic arm,
  input  logic ev,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= 1'b0;
    else if (!live)     q <= 1'b0;
    else if (ev && arm) q <= 1'b1;
    else if (clr)       q <= 1'b0;
  end
endmodule

// File: rtl/det_int_select.sv
module det_int_select
  import det_shadow_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic              short_cmp,
  input  logic [N_STAT-1:0] mask,
  input  logic [N_STAT-1:0] sticky,
  output logic              int_n
);
  always_comb begin
    unique case (det_mode_e'(mode))
      DM_SHORT:  int_n = mask[STAT_DET] ? 1'b1 : short_cmp;
      DM_NORMAL: int_n = ~|(sticky & ~mask);
      default:   int_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/detect_shadow_latch.sv
module detect_shadow_latch
  import det_shadow_pkg::*;
#(
  parameter int WAKE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pri_det_mode,
  input  logic [1:0]        pri_bias_ctl,
  input  logic              pri_tip_en,
  input  logic [WAKE_W-1:0] pri_wake_mask,
  input  logic              latch_xfer,
  input  logic              pdn_all,
  input  logic              short_cmp,
  input  logic [1:0]        stat_mask,
  input  logic [1:0]        stat_ev,
  input  logic [1:0]        stat_clr,
  output logic [1:0]        sh_det_mode,
  output logic [1:0]        sh_bias_ctl,
  output logic              sh_tip_en,
  output logic [WAKE_W-1:0] sh_wake_mask,
  output logic [1:0]        stat_sticky,
  output logic              pwr_down,
  output logic              int_n
);
  logic [1:0] st_mode, st_bias;
  logic       override, live, arm;

  det_shadow_bank #(.WAKE_W(WAKE_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .xfer(latch_xfer),
    .pri_mode(pri_det_mode), .pri_bias(pri_bias_ctl),
    .pri_tip(pri_tip_en), .pri_wake(pri_wake_mask),
    .st_mode(st_mode), .st_bias(st_bias),
    .st_tip(sh_tip_en), .st_wake(sh_wake_mask)
  );

  assign override    = latch_xfer & pdn_all;
  assign pwr_down    = override;
  assign sh_det_mode = override ? DM_OFF : st_mode;
  assign sh_bias_ctl = override ? 2'b00  : st_bias;
  assign live        = mode_live(sh_det_mode);
  assign arm         = ~latch_xfer;

  for (genvar s = 0; s < N_STAT; s++) begin : g_stat
    det_sticky_cell cell_i (
      .clk(clk), .rst_n(rst_n), .live(live), .arm(arm),
      .ev(stat_ev[s]), .clr(stat_clr[s]), .q(stat_sticky[s])
    );
  end

  det_int_select int_i (
    .mode(sh_det_mode), .short_cmp(short_cmp), .mask(stat_mask),
    .sticky(stat_sticky), .int_n(int_n)
  );
endmodule

// File: rtl/detect_shadow_latch_chk.sv
module detect_shadow_latch_chk #(
  parameter int WAKE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch_xfer,
  input logic              pdn_all,
  input logic              pri_tip_en,
  input logic [WAKE_W-1:0] pri_wake_mask,
  input logic [1:0]        sh_det_mode,
  input logic [1:0]        sh_bias_ctl,
  input logic              sh_tip_en,
  input logic [WAKE_W-1:0] sh_wake_mask,
  input logic [1:0]        stat_sticky,
  input logic              pwr_down,
  input logic              int_n
);
  assert_frozen_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_xfer |=> ($stable(sh_tip_en) && $stable(sh_wake_mask)));

  assert_transparent_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_xfer |=> (sh_tip_en == $past(pri_tip_en) && sh_wake_mask == $past(pri_wake_mask)));

  assert_pdn_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_xfer && pdn_all) |-> (pwr_down && sh_det_mode == 2'b00 && sh_bias_ctl == 2'b00));

  assert_pdn_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_xfer |-> !pwr_down);

  assert_no_set_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_xfer |=> ((stat_sticky & ~$past(stat_sticky)) == 2'b00));

  assert_inactive_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_det_mode == 2'b00 || sh_det_mode == 2'b10) |=> (stat_sticky == 2'b00));

  assert_inactive_int_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_det_mode == 2'b00 || sh_det_mode == 2'b10) |-> int_n);
endmodule

bind detect_shadow_latch detect_shadow_latch_chk #(.WAKE_W(WAKE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .latch_xfer(latch_xfer), .pdn_all(pdn_all),
  .pri_tip_en(pri_tip_en), .pri_wake_mask(pri_wake_mask),
  .sh_det_mode(sh_det_mode), .sh_bias_ctl(sh_bias_ctl), .sh_tip_en(sh_tip_en),
  .sh_wake_mask(sh_wake_mask), .stat_sticky(stat_sticky),
  .pwr_down(pwr_down), .int_n(int_n)
);

// File: tb/detect_shadow_latch_tb_top.sv
module detect_shadow_latch_tb_top;
  localparam int WAKE_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pri_det_mode = 2'b00, pri_bias_ctl = 2'b01;
  logic pri_tip_en = 1'b0;
  logic [WAKE_W-1:0] pri_wake_mask = '1;
  logic latch_xfer = 1'b0, pdn_all = 1'b0, short_cmp = 1'b1;
  logic [1:0] stat_mask = 2'b00, stat_ev = 2'b00, stat_clr = 2'b00;
  logic [1:0] sh_det_mode, sh_bias_ctl, stat_sticky;
  logic sh_tip_en, pwr_down, int_n;
  logic [WAKE_W-1:0] sh_wake_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  detect_shadow_latch #(.WAKE_W(WAKE_W)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic load_mode(input logic [1:0] m);
    latch_xfer = 1'b1; pri_det_mode = m; step();
    latch_xfer = 1'b0; step();
  endtask

  task automatic pulse(input logic [1:0] ev, input logic [1:0] clr);
    stat_ev = ev; stat_clr = clr; step();
    stat_ev = 2'b00; stat_clr = 2'b00;
  endtask

  task automatic t_reset;
    chk("R1 mode", sh_det_mode, 2'b00);
    chk("R1 bias", sh_bias_ctl, 2'b01);
    chk("R1 tip", sh_tip_en, 1'b0);
    chk("R1 wake", sh_wake_mask, 2'b11);
    chk("R1 sticky", stat_sticky, 2'b00);
    chk("R1 int_n", int_n, 1'b1);
    chk("R1 pwr_down", pwr_down, 1'b0);
  endtask

  task automatic t_frozen;
    pri_det_mode = 2'b11; pri_bias_ctl = 2'b10; pri_tip_en = 1'b1;
    pri_wake_mask = 2'b00; pdn_all = 1'b1;
    step(3);
    chk("R2 mode held", sh_det_mode, 2'b00);
    chk("R2 bias held", sh_bias_ctl, 2'b01);
    chk("R2 tip held", sh_tip_en, 1'b0);
    chk("R2 wake held", sh_wake_mask, 2'b11);
    chk("R4 pdn ignored when frozen", pwr_down, 1'b0);
    pdn_all = 1'b0;
  endtask

  task automatic t_transparent;
    latch_xfer = 1'b1; step();
    chk("R3 mode", sh_det_mode, 2'b11);
    chk("R3 bias", sh_bias_ctl, 2'b10);
    chk("R3 tip", sh_tip_en, 1'b1);
    chk("R3 wake", sh_wake_mask, 2'b00);
    pri_bias_ctl = 2'b11; pri_wake_mask = 2'b10; step();
    chk("R3 bias follow", sh_bias_ctl, 2'b11);
    chk("R3 wake follow", sh_wake_mask, 2'b10);
    pdn_all = 1'b1; #1;
    chk("R4 pwr_down", pwr_down, 1'b1);
    chk("R4 mode forced", sh_det_mode, 2'b00);
    chk("R4 bias forced", sh_bias_ctl, 2'b00);
    pdn_all = 1'b0; #1;
    chk("R4 release", sh_det_mode, 2'b11);
    latch_xfer = 1'b0; step();
  endtask

  task automatic t_sticky_normal;
    load_mode(2'b11);
    stat_mask = 2'b00;
    pulse(2'b01, 2'b00);
    chk("R5 det set", stat_sticky, 2'b01);
    chk("R10 int low", int_n, 1'b0);
    stat_mask = 2'b01; #1;
    chk("R10 masked", int_n, 1'b1);
    pulse(2'b10, 2'b00);
    chk("R5 rel set", stat_sticky, 2'b11);
    chk("R10 rel unmasked", int_n, 1'b0);
    pulse(2'b00, 2'b01);
    chk("R7 det cleared", stat_sticky, 2'b10);
    pulse(2'b10, 2'b10);
    chk("R7 set wins", stat_sticky, 2'b10);
    pulse(2'b00, 2'b10);
    chk("R7 rel cleared", stat_sticky, 2'b00);
    chk("R10 idle high", int_n, 1'b1);
    stat_mask = 2'b00;
  endtask

  task automatic t_ignore;
    latch_xfer = 1'b1; pri_det_mode = 2'b11;
    pulse(2'b11, 2'b00);
    chk("R6 strobes ignored", stat_sticky, 2'b00);
    latch_xfer = 1'b0; step();
  endtask

  task automatic t_inactive;
    pulse(2'b01, 2'b00);
    chk("R5 set before mode change", stat_sticky, 2'b01);
    latch_xfer = 1'b1; pri_det_mode = 2'b10; step();
    chk("R11 int high in 10", int_n, 1'b1);
    step();
    chk("R8 cleared in 10", stat_sticky, 2'b00);
    latch_xfer = 1'b0; step();
    pulse(2'b11, 2'b00);
    chk("R8 no set in 10", stat_sticky, 2'b00);
    load_mode(2'b00);
    pulse(2'b11, 2'b00);
    chk("R8 no set in 00", stat_sticky, 2'b00);
    chk("R11 int high in 00", int_n, 1'b1);
  endtask

  task automatic t_short;
    load_mode(2'b01);
    stat_mask = 2'b00; short_cmp = 1'b0; #1;
    chk("R9 follows cmp low", int_n, 1'b0);
    short_cmp = 1'b1; #1;
    chk("R9 follows cmp high", int_n, 1'b1);
    short_cmp = 1'b0; #1;
    chk("R9 no lag", int_n, 1'b0);
    stat_mask = 2'b01; #1;
    chk("R9 mask holds high", int_n, 1'b1);
    stat_mask = 2'b00; short_cmp = 1'b1;
    pulse(2'b01, 2'b00);
    chk("R5 set in short mode", stat_sticky, 2'b01);
    chk("R9 sticky not routed", int_n, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_frozen();
    t_transparent();
    t_sticky_normal();
    t_ignore();
    t_inactive();
    t_short();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule